// File: doc/BRIEF.md
# Per-Partition Supply Calibration Controller

This controller holds one supply-setting code for each of several logic partitions of a multiply-accumulate array. It drives the codes to an external power-delivery unit. On reset every code starts from a coarse estimate. The operating span from the crash voltage up to the minimum safe voltage is cut into equal bands, one per partition. Partition i starts at the centre of band i, counted upward from the crash end. The first cycle after reset raises every update pulse once, so the regulator can latch these starting codes.

During a trial pass before normal operation, software raises the calibrate enable. Each partition brings in one timing-failure flag per multiply-accumulate unit it contains. The controller ORs these flags together over an evaluation window whose length is programmable. When the window closes, every partition takes exactly one step. A partition that saw any failure steps up one code. A partition that stayed clean for the whole window steps down one code. Codes saturate at both ends of the span. The partitions are independent of each other.

A three-state sequencer controls all partitions. `ST_ANNOUNCE` is the single post-reset cycle that pulses all update strobes; it moves to `ST_IDLE` unconditionally. `ST_IDLE` holds the codes and keeps the accumulators clear; it moves to `ST_EVAL` when calibrate enable is sampled high. `ST_EVAL` counts window cycles. It applies a step on the last cycle and then starts a new window. It returns to `ST_IDLE`, discarding the partial window, when calibrate enable is sampled low.

Top module: `vcal_ctrl`

## Requirements
- R1: While reset is asserted, and after it, partition i holds code CRASH + i*B + B/2, where B = (MIN - CRASH)/N in integer division. The defaults are CRASH=950, MIN=1000, N=4, one code per millivolt, giving 956, 968, 980 and 992. Partition i occupies `vcode[i*11 +: 11]`. Its flags are `fail_flags[i*64 +: 64]`.
- R2: On the first clock edge after reset is released, all bits of `vcode_chg` go high for exactly one cycle, and the codes do not change.
- R3: If any flag of a partition is high in any sampled cycle of a window, that partition's code rises by exactly one at the window end.
- R4: If every flag of a partition is low throughout a window, that partition's code falls by exactly one at the window end.
- R5: A window begins on the edge after calibrate enable is sampled high in idle. It samples flags on `win_len`+1 consecutive edges. A flag that is high on only one of those edges, first or last, still counts. Each window produces at most one step per partition, and the next window follows immediately.
- R6: A code never rises above MIN (1000) and never falls below CRASH (950). It does not wrap.
- R7: While `cal_en` is low, codes hold whatever the flags do. Dropping `cal_en` mid-window discards that window's accumulated flags without stepping.
- R8: `vcode_chg[i]` is high for one cycle, together with the new code, whenever code i changes value. It stays low when a saturated step leaves the code unchanged.
- R9: Each partition steps only on its own flags. Failures in one partition do not affect the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_en | input | 1 | Enables calibration stepping |
| win_len | input | 4 | Window length minus one, in cycles |
| fail_flags | input | 256 | Timing-failure flags, 64 per partition |
| vcode | output | 44 | Supply codes, 11 bits per partition |
| vcode_chg | output | 4 | One-cycle update strobe per partition |

## Verification
A table of windows exercises four aspects of the main function. Mixed error masks across the partitions show that the partitions step independently. Window lengths from 1 to 8 cycles test the window timing. A flag that is set only on the first or only on the last sampled cycle shows whether the OR accumulation and the final-cycle merge both work. All-error runs and all-clean runs drive every code into the top and bottom limits, which separates a correct saturation from a wrap-around or a spurious update strobe. An aborted window followed by a clean one shows whether discarded errors leak into the next step. A long disabled stretch with all flags high shows that the codes stay where they are.

// File: rtl/vcal_pkg.sv
package vcal_pkg;

    typedef enum logic [1:0] {
        ST_ANNOUNCE,
        ST_IDLE,
        ST_EVAL
    } cal_state_e;

    // Centre of band idx when [lo,hi] is cut into n equal integer bands.
    function automatic int seed_code(input int idx, input int n, input int lo, input int hi);
        int band;
        band = (hi - lo) / n;
        return lo + idx * band + band / 2;
    endfunction

endpackage

// File: rtl/vcal_seq.sv
module vcal_seq #(
    parameter int WIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_en,
    input  logic [WIN_W-1:0] win_len,
    output logic             announce,
    output logic             acc_clr,
    output logic             acc_en,
    output logic             apply
);
    import vcal_pkg::*;

    cal_state_e       state, nxt;
    logic [WIN_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ANNOUNCE;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        announce = 1'b0;
        acc_clr  = 1'b0;
        acc_en   = 1'b0;
        apply    = 1'b0;
        unique case (state)
            ST_ANNOUNCE: begin
                announce = 1'b1;
                nxt      = ST_IDLE;
            end
            ST_IDLE: begin
                acc_clr = 1'b1;
                if (cal_en) nxt = ST_EVAL;
            end
            ST_EVAL: begin
                if (!cal_en) begin
                    acc_clr = 1'b1;
                    nxt     = ST_IDLE;
                end else if (cnt == win_len) begin
                    apply = 1'b1;
                end else begin
                    acc_en = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         cnt <= '0;
        else if (state == ST_EVAL && cal_en && cnt != win_len) cnt <= cnt + 1'b1;
        else                                                cnt <= '0;
    end

    // R7: no step is ever taken while calibration is disabled
    a_r7_no_step_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |-> !apply);

    // R2: the announce cycle happens once and is followed by idle behaviour
    a_r2_announce_once: assert property (@(posedge clk) disable iff (!rst_n)
        announce |=> !announce);

endmodule

// File: rtl/vcal_part.sv
module vcal_part #(
    parameter int UNITS   = 64,
    parameter int CODE_W  = 11,
    parameter int SEED    = 956,
    parameter int LO_CODE = 950,
    parameter int HI_CODE = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UNITS-1:0]  flags,
    input  logic              announce,
    input  logic              acc_clr,
    input  logic              acc_en,
    input  logic              apply,
    output logic [CODE_W-1:0] code,
    output logic              chg
);
    localparam logic [CODE_W-1:0] SEED_C = CODE_W'(SEED);
    localparam logic [CODE_W-1:0] LO_C   = CODE_W'(LO_CODE);
    localparam logic [CODE_W-1:0] HI_C   = CODE_W'(HI_CODE);

    logic any_now;
    logic acc;
    logic saw_err;

    assign any_now = |flags;
    assign saw_err = acc | any_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= 1'b0;
            code <= SEED_C;
            chg  <= 1'b0;
        end else begin
            chg <= announce;
            if (acc_clr) begin
                acc <= 1'b0;
            end else if (apply) begin
                acc <= 1'b0;
                if (saw_err) begin
                    if (code < HI_C) begin
                        code <= code + 1'b1;
                        chg  <= 1'b1;
                    end
                end else if (code > LO_C) begin
                    code <= code - 1'b1;
                    chg  <= 1'b1;
                end
            end else if (acc_en) begin
                acc <= saw_err;
            end
        end
    end

    // R6: code stays inside the operating span
    a_r6_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= LO_C) && (code <= HI_C));

    // R3 / R4: a window end moves the code by one step at most
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (code == $past(code) + 1'b1) || (code == $past(code) - 1'b1) || (code == $past(code)));

    // R7: without a window end the code cannot move
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(code));

    // R8: every change of code comes with its strobe
    a_r8_chg_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> chg);

endmodule

// File: rtl/vcal_ctrl.sv
module vcal_ctrl #(
    parameter int NUM_PART   = 4,
    parameter int UNITS      = 64,
    parameter int CODE_W     = 11,
    parameter int WIN_W      = 4,
    parameter int V_CRASH_MV = 950,
    parameter int V_MIN_MV   = 1000,
    parameter int STEP_MV    = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cal_en,
    input  logic [WIN_W-1:0]             win_len,
    input  logic [NUM_PART*UNITS-1:0]    fail_flags,
    output logic [NUM_PART*CODE_W-1:0]   vcode,
    output logic [NUM_PART-1:0]          vcode_chg
);
    localparam int CRASH_CODE = V_CRASH_MV / STEP_MV;
    localparam int MIN_CODE   = V_MIN_MV / STEP_MV;

    logic announce, acc_clr, acc_en, apply;

    vcal_seq #(.WIN_W(WIN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cal_en   (cal_en),
        .win_len  (win_len),
        .announce (announce),
        .acc_clr  (acc_clr),
        .acc_en   (acc_en),
        .apply    (apply)
    );

    for (genvar g = 0; g < NUM_PART; g++) begin : g_part
        vcal_part #(
            .UNITS   (UNITS),
            .CODE_W  (CODE_W),
            .SEED    (vcal_pkg::seed_code(g, NUM_PART, CRASH_CODE, MIN_CODE)),
            .LO_CODE (CRASH_CODE),
            .HI_CODE (MIN_CODE)
        ) u_part (
            .clk      (clk),
            .rst_n    (rst_n),
            .flags    (fail_flags[g*UNITS +: UNITS]),
            .announce (announce),
            .acc_clr  (acc_clr),
            .acc_en   (acc_en),
            .apply    (apply),
            .code     (vcode[g*CODE_W +: CODE_W]),
            .chg      (vcode_chg[g])
        );
    end

endmodule

// File: tb/test_vcal_ctrl.sv
module test_vcal_ctrl;
    localparam int NP = 4;
    localparam int UN = 64;
    localparam int CW = 11;
    localparam int WW = 4;
    localparam int LO = 950;
    localparam int HI = 1000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cal_en;
    logic [WW-1:0]      win_len;
    logic [NP*UN-1:0]   fail_flags;
    logic [NP*CW-1:0]   vcode;
    logic [NP-1:0]      vcode_chg;

    always #5 clk = ~clk;

    vcal_ctrl i_vcal_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_en     (cal_en),
        .win_len    (win_len),
        .fail_flags (fail_flags),
        .vcode      (vcode),
        .vcode_chg  (vcode_chg)
    );

    int n_chk = 0;
    int n_bad = 0;
    int model [NP];
    int seed  [NP];

    // fields: [8:5] error mask per partition, [4:1] win_len, [0] flag on last cycle
    localparam logic [8:0] VEC [8] = '{
        {4'b0000, 4'd0, 1'b0},
        {4'b1111, 4'd0, 1'b0},
        {4'b0101, 4'd3, 1'b0},
        {4'b1010, 4'd3, 1'b1},
        {4'b0001, 4'd7, 1'b1},
        {4'b1000, 4'd1, 1'b0},
        {4'b0110, 4'd5, 1'b0},
        {4'b0000, 4'd2, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_of(input int p);
        return int'(vcode[p*CW +: CW]);
    endfunction

    task automatic check_all(input string req, input logic [NP-1:0] exp_chg);
        for (int p = 0; p < NP; p++) check(req, code_of(p), model[p]);
        check({req, " strobe"}, int'(vcode_chg), int'(exp_chg));
    endtask

    // one full window from idle; returns at the negedge after the step edge
    task automatic run_window(input logic [NP-1:0] mask, input int wl, input bit last,
                              input int unit, input string req);
        logic [NP*UN-1:0] pat;
        logic [NP-1:0]    exp_chg;
        pat = '0;
        for (int p = 0; p < NP; p++) if (mask[p]) pat[p*UN + unit] = 1'b1;
        @(negedge clk);
        cal_en  = 1'b1;
        win_len = WW'(wl);
        fail_flags = '0;
        @(negedge clk);
        for (int c = 0; c <= wl; c++) begin
            fail_flags = (c == (last ? wl : 0)) ? pat : '0;
            @(negedge clk);
        end
        cal_en = 1'b0;
        fail_flags = '0;
        exp_chg = '0;
        for (int p = 0; p < NP; p++) begin
            int nv;
            nv = mask[p] ? ((model[p] < HI) ? model[p] + 1 : HI)
                         : ((model[p] > LO) ? model[p] - 1 : LO);
            if (nv != model[p]) exp_chg[p] = 1'b1;
            model[p] = nv;
        end
        check_all(req, exp_chg);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int band;
        band = (HI - LO) / NP;
        for (int p = 0; p < NP; p++) begin
            seed[p]  = LO + p * band + band / 2;
            model[p] = seed[p];
        end
        rst_n = 1'b0;
        cal_en = 1'b0;
        win_len = '0;
        fail_flags = '0;
        repeat (3) @(negedge clk);

        // R1: seeds while held in reset
        check_all("R1 reset seeds", '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: announce strobe on all partitions, codes unchanged
        check_all("R2 announce", 4'b1111);
        @(negedge clk);
        check_all("R2 announce ends", '0);

        // R3 R4 R5 R9: table of windows
        for (int v = 0; v < 8; v++) begin
            run_window(VEC[v][8:5], int'(VEC[v][4:1]), VEC[v][0], (v * 7) % UN,
                       "R3 R4 R5 R9 vector");
            @(negedge clk);
        end

        // R7: abort mid-window with errors, then a clean window must step down
        @(negedge clk);
        cal_en = 1'b1;
        win_len = 4'd5;
        fail_flags = '1;
        repeat (3) @(negedge clk);
        cal_en = 1'b0;
        @(negedge clk);
        fail_flags = '0;
        check_all("R7 abort holds", '0);
        run_window(4'b0000, 0, 1'b0, 0, "R7 aborted errors discarded");
        @(negedge clk);

        // R7: disabled with all flags high
        fail_flags = '1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (c == 19) check_all("R7 disabled hold", '0);
        end
        fail_flags = '0;

        // R6 R8: saturate high
        for (int k = 0; k < 55; k++) begin
            run_window(4'b1111, 0, 1'b0, 63, "R6 R8 top limit");
            @(negedge clk);
        end
        // R6 R8: saturate low
        for (int k = 0; k < 55; k++) begin
            run_window(4'b0000, 1, 1'b0, 0, "R6 R8 bottom limit");
            @(negedge clk);
        end

        // R1: reset mid-run restores seeds
        rst_n = 1'b0;
        @(negedge clk);
        for (int p = 0; p < NP; p++) model[p] = seed[p];
        check_all("R1 reset restores seeds", '0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule